// File: doc/BRIEF.md
# Dual-Threshold Wake-Up Qualifier

This block decides when a controller sitting in its low-power waiting state has been asked to wake up. It watches two digital comparator flags derived from the voltage-sense input: one set when the sensed signal is above a high threshold (about 2 V), the other set when it is above a low threshold (about 57 mV). The high path suits a strong, low-impedance signalling driver. The low path suits a weak, high-impedance one. The two paths run side by side and neither depends on the other.

A path may declare a wake-up only after its own flag has stayed low without a break for a qualification interval of 8.5 µs. That interval is counted from the most recent end-of-demagnetization pulse. Once a path is armed, a rising flag on that path produces a one-cycle wake pulse. The interval is given in nanoseconds and turned into a clock-cycle count through a clock-frequency parameter. Both comparator flags are asynchronous and pass through a two-stage synchronizer before the qualifiers see them.

Top module: `wuq_wake_detector`

## Requirements
- R1: While `wait_en` is low, `wake` stays low and both paths are cleared (timer zero, not armed, not running).
- R2: The high and low paths qualify and fire independently. A wake-up from either path alone drives `wake`.
- R3: A path arms after its synchronized flag has been sampled low on QUAL_N consecutive clock edges following a `demag_end` pulse. QUAL_N = ceil(CLK_HZ × QUAL_NS / 1e9), with a minimum of 1.
- R4: When an armed path sees its flag high, `wake` rises. A flag change at the pin reaches `wake` three clock edges later: two synchronizer stages and one output register.
- R5: A flag sampled high before its path has armed clears that path's timer. Arming then needs a fresh, uninterrupted run of QUAL_N low samples.
- R6: A `demag_end` pulse (active high, one cycle) restarts both timers and disarms both paths. A wake-up that would coincide with that pulse is suppressed.
- R7: `wake` is high for exactly one cycle. After it fires, both paths stay disarmed until the next `demag_end`.
- R8: The synchronous active-high reset `rst` clears the synchronizer, timers, arm flags and `wake`.
- R9: After `wait_en` rises, no path arms until a `demag_end` pulse has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_en | input | 1 | High while the controller is in its waiting state |
| demag_end | input | 1 | One-cycle pulse marking the end of demagnetization |
| cmp_hi_async | input | 1 | Asynchronous flag: sensed voltage above the high threshold |
| cmp_lo_async | input | 1 | Asynchronous flag: sensed voltage above the low threshold |
| wake | output | 1 | Registered one-cycle wake-up request |

## Verification
The bench probes the arming boundary from both sides. If the count is off by one, the design would wake after QUAL_N−1 low samples, or would ignore a flag that arrives right after QUAL_N. A single-cycle high blip in the middle of the interval is used to catch a timer that pauses instead of restarting; such a design would wake too early. Other directed cases fire one path while the other never arms, then keep a flag high after a wake, then raise a flag before any `demag_end`, then drop `wait_en` while a path is armed. Each of these exposes a wake that is missing, repeated or early. A seeded random phase mixes all these events and compares `wake` on every cycle against a reference model in the bench.

// File: rtl/wuq_pkg.sv
package wuq_pkg;

    // Index of each detection path inside the path vectors.
    typedef enum int {
        PATH_HI = 0,
        PATH_LO = 1
    } path_idx_e;

    localparam int NUM_PATHS = 2;

    // Per-path control flags.
    typedef struct packed {
        logic running;  // a demag end has started this path's qualification
        logic armed;    // full quiet interval has elapsed
    } qual_flags_t;

    // Cycles needed to cover delay_ns at clk_hz, rounded up, at least one.
    function automatic int qual_cycles(input longint clk_hz, input longint delay_ns);
        longint prod;
        longint cyc;
        prod = clk_hz * delay_ns;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc < 1) cyc = 1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/wuq_sync2.sv
module wuq_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/wuq_qual_path.sv
module wuq_qual_path
    import wuq_pkg::*;
#(
    parameter int QUAL_N = 1700
) (
    input  logic clk,
    input  logic rst,
    input  logic wait_en,
    input  logic demag_end,
    input  logic kill,
    input  logic cmp,
    output logic armed,
    output logic fire
);
    localparam int CNT_W = (QUAL_N > 1) ? $clog2(QUAL_N) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_N - 1);

    qual_flags_t      flags;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !wait_en) begin
            flags <= '0;
            cnt   <= '0;
        end else if (demag_end) begin
            flags.running <= 1'b1;
            flags.armed   <= 1'b0;
            cnt           <= '0;
        end else if (kill) begin
            flags <= '0;
            cnt   <= '0;
        end else if (flags.running && !flags.armed) begin
            if (cmp) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                flags.armed <= 1'b1;
                cnt         <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign armed = flags.armed;
    assign fire  = flags.armed & cmp;

    // R6: a demag end while waiting leaves the path disarmed with a zero timer
    a_r6_demag_disarms: assert property (@(posedge clk) disable iff (rst)
        (demag_end && wait_en) |=> (!armed && cnt == '0));

    // R5: a high flag during qualification restarts the timer
    a_r5_high_restarts: assert property (@(posedge clk) disable iff (rst)
        (wait_en && !demag_end && !kill && flags.running && !armed && cmp)
        |=> (cnt == '0 && !armed));

    // R3: arming only follows the final count of the quiet window
    a_r3_arm_at_count: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> ($past(cnt) == LAST && !$past(cmp)));

    // R9: never armed without having been started by a demag end
    a_r9_arm_needs_start: assert property (@(posedge clk) disable iff (rst)
        armed |-> flags.running);
endmodule

// File: rtl/wuq_wake_detector.sv
module wuq_wake_detector
    import wuq_pkg::*;
#(
    parameter longint CLK_HZ  = 200_000_000,
    parameter longint QUAL_NS = 8500
) (
    input  logic clk,
    input  logic rst,
    input  logic wait_en,
    input  logic demag_end,
    input  logic cmp_hi_async,
    input  logic cmp_lo_async,
    output logic wake
);
    localparam int QUAL_N = qual_cycles(CLK_HZ, QUAL_NS);

    logic [NUM_PATHS-1:0] cmp_raw;
    logic [NUM_PATHS-1:0] cmp_s;
    logic [NUM_PATHS-1:0] armed_vec;
    logic [NUM_PATHS-1:0] fire_vec;
    logic                 any_fire;

    assign cmp_raw[PATH_HI] = cmp_hi_async;
    assign cmp_raw[PATH_LO] = cmp_lo_async;

    wuq_sync2 #(.W(NUM_PATHS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cmp_raw),
        .sync_out (cmp_s)
    );

    assign any_fire = wait_en & ~demag_end & (|fire_vec);

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        wuq_qual_path #(.QUAL_N(QUAL_N)) u_path (
            .clk       (clk),
            .rst       (rst),
            .wait_en   (wait_en),
            .demag_end (demag_end),
            .kill      (any_fire),
            .cmp       (cmp_s[p]),
            .armed     (armed_vec[p]),
            .fire      (fire_vec[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) wake <= 1'b0;
        else     wake <= any_fire;
    end

    // R1: no wake request produced outside the waiting state
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !wait_en |=> !wake);

    // R7: wake never lasts two cycles
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    // R4: a wake requires an armed path on the previous edge
    a_r4_wake_needs_arm: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(|armed_vec));

    // R7: both paths are disarmed right after a wake
    a_r7_disarm_after_wake: assert property (@(posedge clk) disable iff (rst)
        wake |-> (armed_vec == '0));
endmodule

// File: tb/wuq_wake_detector_tb.sv
`timescale 1ns/1ps
module wuq_wake_detector_tb;
    localparam longint CLK_HZ  = 200_000_000;
    localparam longint QUAL_NS = 500;
    localparam int     N = int'((CLK_HZ * QUAL_NS + 64'd999_999_999) / 64'd1_000_000_000);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wait_en = 1'b0;
    logic demag_end = 1'b0;
    logic cmp_hi = 1'b0;
    logic cmp_lo = 1'b0;
    logic wake;

    int checks = 0;
    int errors = 0;
    int wakes_seen = 0;
    string cur_req = "R8";

    always #2.5 clk = ~clk;

    wuq_wake_detector #(.CLK_HZ(CLK_HZ), .QUAL_NS(QUAL_NS)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .wait_en      (wait_en),
        .demag_end    (demag_end),
        .cmp_hi_async (cmp_hi),
        .cmp_lo_async (cmp_lo),
        .wake         (wake)
    );

    // Reference model built from the requirements.
    logic [1:0] m_s1, m_s2;
    int         m_cnt [2];
    logic [1:0] m_arm, m_run;
    logic       m_wake;

    always @(posedge clk) begin
        logic [1:0] f;
        logic       any;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_arm = 0; m_run = 0; m_wake = 0;
            m_cnt[0] = 0; m_cnt[1] = 0;
        end else begin
            f   = m_arm & m_s2;
            any = wait_en && !demag_end && (f != 0);
            for (int p = 0; p < 2; p++) begin
                if (!wait_en) begin
                    m_run[p] = 0; m_arm[p] = 0; m_cnt[p] = 0;
                end else if (demag_end) begin
                    m_run[p] = 1; m_arm[p] = 0; m_cnt[p] = 0;
                end else if (any) begin
                    m_run[p] = 0; m_arm[p] = 0; m_cnt[p] = 0;
                end else if (m_run[p] && !m_arm[p]) begin
                    if (m_s2[p]) m_cnt[p] = 0;
                    else begin
                        m_cnt[p] = m_cnt[p] + 1;
                        if (m_cnt[p] == N) begin m_arm[p] = 1; m_cnt[p] = 0; end
                    end
                end
            end
            m_wake = any;
            m_s2 = m_s1;
            m_s1 = {cmp_lo, cmp_hi};
        end
    end

    // One cycle: compare at the falling edge, then drive the next inputs.
    task automatic step(input logic w, input logic d, input logic h, input logic l);
        @(negedge clk);
        checks++;
        if (wake !== m_wake) begin
            errors++;
            $display("FAIL %s: wake actual %0b expected %0b at %0t", cur_req, wake, m_wake, $time);
        end
        if (wake === 1'b1) wakes_seen++;
        wait_en = w; demag_end = d; cmp_hi = h; cmp_lo = l;
    endtask

    task automatic hold(input int n, input logic h, input logic l);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, h, l);
    endtask

    task automatic demag();
        step(1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic expect_count(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: wake count actual %0d expected %0d", req, got, exp);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd20240611));
        // R8: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (wake !== 1'b0) begin
            errors++;
            $display("FAIL R8: wake actual %0b expected 0", wake);
        end
        @(negedge clk); rst = 1'b0;

        // R3: arm boundary, flag just after full quiet window
        cur_req = "R3";
        base = wakes_seen;
        demag(); hold(N + 2, 0, 0); hold(4, 1, 1); hold(6, 0, 0);
        expect_count("R3", wakes_seen - base, 1);

        // R3: flag one cycle too early gives no wake
        base = wakes_seen;
        demag(); hold(N - 3, 0, 0); hold(1, 1, 0); hold(6, 0, 0);
        expect_count("R3", wakes_seen - base, 0);

        // R5: mid-window blip restarts the timer
        cur_req = "R5";
        base = wakes_seen;
        demag(); hold(N / 2, 0, 0); hold(1, 1, 0); hold(N - 4, 0, 0); hold(1, 1, 0); hold(4, 0, 0);
        expect_count("R5", wakes_seen - base, 0);
        hold(N, 0, 0); hold(1, 1, 0); hold(5, 0, 0);
        expect_count("R5", wakes_seen - base, 1);

        // R2: low flag busy keeps low path unarmed, high path alone fires
        cur_req = "R2";
        base = wakes_seen;
        demag(); hold(N / 2, 0, 1); hold(N + 4, 0, 0); hold(1, 1, 0); hold(5, 0, 0);
        expect_count("R2", wakes_seen - base, 1);
        base = wakes_seen;
        demag(); hold(N + 4, 0, 0); hold(2, 0, 1); hold(5, 0, 0);
        expect_count("R2", wakes_seen - base, 1);

        // R4: exact latency checked by the model on every cycle
        cur_req = "R4";
        demag(); hold(N + 3, 0, 0); hold(1, 0, 1); hold(5, 0, 0);

        // R6: demag just before a flag rise cancels arming
        cur_req = "R6";
        base = wakes_seen;
        demag(); hold(N + 3, 0, 0); demag(); hold(1, 1, 1); hold(6, 0, 0);
        expect_count("R6", wakes_seen - base, 0);

        // R7: flags stay or return high after a wake, no repeat
        cur_req = "R7";
        base = wakes_seen;
        demag(); hold(N + 3, 0, 0); hold(8, 1, 1); hold(N + 4, 0, 0); hold(3, 1, 1); hold(4, 0, 0);
        expect_count("R7", wakes_seen - base, 1);

        // R1: dropping wait while armed, then flag high
        cur_req = "R1";
        base = wakes_seen;
        demag(); hold(N + 3, 0, 0);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, (i > 2), (i > 2));
        expect_count("R1", wakes_seen - base, 0);

        // R9: waiting with no demag end, long quiet, then flag
        cur_req = "R9";
        base = wakes_seen;
        hold(2 * N, 0, 0); hold(3, 1, 1); hold(5, 0, 0);
        expect_count("R9", wakes_seen - base, 0);

        // R2: seeded random mix checked against the model
        cur_req = "R2";
        for (int i = 0; i < 40000; i++) begin
            logic w, d, h, l;
            w = ($urandom_range(0, 999) != 0) ? 1'b1 : ~wait_en;
            if (!wait_en && $urandom_range(0, 19) != 0) w = 1'b0;
            d = ($urandom_range(0, 3 * N) == 0);
            h = ($urandom_range(0, 2 * N) == 0) ? 1'b1 : (cmp_hi && $urandom_range(0, 3) != 0);
            l = ($urandom_range(0, 2 * N) == 0) ? 1'b1 : (cmp_lo && $urandom_range(0, 3) != 0);
            step(w, d, h, l);
        end

        // R8: reset mid-run clears everything
        cur_req = "R8";
        demag(); hold(N + 3, 0, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        hold(3, 1, 1); hold(4, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule